// File: doc/BRIEF.md
# Sequential Integer Multiply/Divide Unit with HI/LO Result Pair

This block computes integer products and quotients one bit per clock and keeps its results in a private pair of 32-bit registers, HI and LO. The pipeline launches an operation with a one-cycle `start` pulse that carries a 2-bit operation code and two register operands. There is no immediate form. A multiply leaves the upper half of its 64-bit product in HI and the lower half in LO. A divide leaves the remainder in HI and the quotient in LO. Signed and unsigned variants are selected by the operation code.

Software sees HI and LO only through explicit moves. A read port returns a copy of either register. A write port loads either register, or both, from a source operand. While an operation is in flight, `busy` is high and `rd_ready` is low, so the pipeline can hold a move-from until the result has landed instead of consuming a stale value.

Top module: `muldiv_unit`

## Requirements
- R1: After reset HI and LO hold zero, `busy` is 0 and `rd_ready` is 1.
- R2: A `start` seen while idle raises `busy` on that clock edge. `busy` stays high for exactly 32 cycles. HI and LO take the result on the edge where `busy` falls. The `op` encoding is: bit 1 set means divide, bit 0 set means unsigned. So 00 is signed multiply, 01 is unsigned multiply, 10 is signed divide and 11 is unsigned divide.
- R3: For an unsigned multiply, {HI, LO} equals the 64-bit product of both operands taken as unsigned.
- R4: For a signed multiply, {HI, LO} equals the 64-bit two's-complement product.
- R5: For an unsigned divide by a nonzero divisor, LO is the quotient and HI is the remainder.
- R6: For a signed divide by a nonzero divisor, the quotient truncates toward zero and the remainder carries the dividend's sign. The most negative value divided by -1 gives LO = 0x80000000 and HI = 0.
- R7: Divide by zero takes the normal 32 cycles. In the unsigned case LO = 0xFFFFFFFF and HI = dividend. In the signed case HI = dividend, and LO = 1 if the dividend is negative, else 0xFFFFFFFF.
- R8: `rd_data` is a combinational copy of HI when `rd_sel` = 1, or of LO when `rd_sel` = 0, while `rd_req` is high. It is zero when `rd_req` is low. `rd_ready` is 1 whenever the unit is idle.
- R9: While `busy` is high, `rd_ready` is 0.
- R10: While idle, `wr_hi` loads HI and `wr_lo` loads LO from `wr_data` on the next edge. Both may be asserted together.
- R11: A move-to asserted while `busy` is high has no effect. This includes the completion cycle.
- R12: A `start` asserted while `busy` is high is ignored. The running operation completes with its own result and on its own schedule.
- R13: A read in the same cycle as an accepted `start` returns the value held before the operation, with `rd_ready` = 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| start | input | 1 | Launch pulse for an operation |
| op | input | 2 | Operation code: bit 1 = divide, bit 0 = unsigned |
| src_a | input | 32 | Multiplicand or dividend |
| src_b | input | 32 | Multiplier or divisor |
| busy | output | 1 | Operation in flight |
| rd_req | input | 1 | Move-from request |
| rd_sel | input | 1 | Read select: 1 = HI, 0 = LO |
| rd_data | output | 32 | Selected register copy |
| rd_ready | output | 1 | Read data is current |
| wr_hi | input | 1 | Move-to HI |
| wr_lo | input | 1 | Move-to LO |
| wr_data | input | 32 | Move-to source operand |

## Verification
Two pairs of functions can collide in one cycle. The first pair is a move-to and the completion of an operation. The bench holds `wr_hi` and `wr_lo` high with a marker value through every busy cycle, including the last one, and then expects the arithmetic result in both registers. The second pair is a move-from and a new launch. The bench asserts `start` together with `rd_req`, and in that cycle expects the pre-operation contents with `rd_ready` high. The behavioural model updates only at the edge, so both the old value in that cycle and the new value after completion are judged on every clock.

// File: rtl/muldiv_pkg.sv
package muldiv_pkg;

  typedef enum logic [1:0] {
    OP_MUL_S = 2'b00,
    OP_MUL_U = 2'b01,
    OP_DIV_S = 2'b10,
    OP_DIV_U = 2'b11
  } md_op_e;

  function automatic logic op_is_div(input logic [1:0] code);
    return code[1];
  endfunction

  function automatic logic op_is_unsigned(input logic [1:0] code);
    return code[0];
  endfunction

endpackage

// File: rtl/md_prep.sv
// Operand conditioning: magnitudes and the sign-fix flags for the result.
module md_prep #(
  parameter int W = 32
) (
  input  logic [1:0]     op,
  input  logic [W-1:0]   a,
  input  logic [W-1:0]   b,
  output logic [2*W-1:0] work_init,
  output logic [W-1:0]   mcand_init,
  output logic           is_div,
  output logic           neg_prod,
  output logic           neg_quo,
  output logic           neg_rem
);
  import muldiv_pkg::*;

  function automatic logic [W-1:0] magnitude(input logic [W-1:0] x, input logic neg);
    return neg ? (~x + 1'b1) : x;
  endfunction

  logic sgn_a, sgn_b;
  logic [W-1:0] mag_a, mag_b;

  always_comb begin
    sgn_a  = !op_is_unsigned(op) && a[W-1];
    sgn_b  = !op_is_unsigned(op) && b[W-1];
    mag_a  = magnitude(a, sgn_a);
    mag_b  = magnitude(b, sgn_b);
    is_div = op_is_div(op);
    if (is_div) begin
      work_init  = {{W{1'b0}}, mag_a};
      mcand_init = mag_b;
    end else begin
      work_init  = {{W{1'b0}}, mag_b};
      mcand_init = mag_a;
    end
    neg_prod = !is_div && (sgn_a ^ sgn_b);
    neg_quo  = is_div && (sgn_a ^ sgn_b);
    neg_rem  = is_div && sgn_a;
  end

endmodule

// File: rtl/md_core.sv
// One-bit-per-cycle shift-add multiply / restoring divide engine.
module md_core #(
  parameter int W = 32
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           load,
  input  logic [2*W-1:0] work_init,
  input  logic [W-1:0]   mcand_init,
  input  logic           is_div_in,
  input  logic           neg_prod_in,
  input  logic           neg_quo_in,
  input  logic           neg_rem_in,
  output logic           busy,
  output logic           done,
  output logic [2*W-1:0] raw,
  output logic           is_div,
  output logic           neg_prod,
  output logic           neg_quo,
  output logic           neg_rem
);
  localparam int CNT_W = $clog2(W);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(W - 1);

  // Product register: upper half accumulates, lower half holds the
  // unconsumed multiplier bits, shifted right each step.
  function automatic logic [2*W-1:0] mul_step(input logic [2*W-1:0] w, input logic [W-1:0] m);
    logic [W:0] sum;
    sum = {1'b0, w[2*W-1:W]} + (w[0] ? {1'b0, m} : {(W+1){1'b0}});
    return {sum, w[W-1:1]};
  endfunction

  // Remainder in the upper half, dividend/quotient bits in the lower half.
  function automatic logic [2*W-1:0] div_step(input logic [2*W-1:0] w, input logic [W-1:0] d);
    logic [W:0] shifted;
    logic [W:0] diff;
    logic       fits;
    shifted = w[2*W-1:W-1];
    fits    = shifted >= {1'b0, d};
    diff    = shifted - {1'b0, d};
    return {fits ? diff[W-1:0] : shifted[W-1:0], w[W-2:0], fits};
  endfunction

  logic [2*W-1:0]   work;
  logic [W-1:0]     mcand;
  logic [CNT_W-1:0] cnt;

  assign raw  = is_div ? div_step(work, mcand) : mul_step(work, mcand);
  assign done = busy && (cnt == LAST);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy     <= 1'b0;
      cnt      <= '0;
      work     <= '0;
      mcand    <= '0;
      is_div   <= 1'b0;
      neg_prod <= 1'b0;
      neg_quo  <= 1'b0;
      neg_rem  <= 1'b0;
    end else if (load) begin
      busy     <= 1'b1;
      cnt      <= '0;
      work     <= work_init;
      mcand    <= mcand_init;
      is_div   <= is_div_in;
      neg_prod <= neg_prod_in;
      neg_quo  <= neg_quo_in;
      neg_rem  <= neg_rem_in;
    end else if (busy) begin
      work <= raw;
      cnt  <= cnt + 1'b1;
      if (cnt == LAST) busy <= 1'b0;
    end
  end

endmodule

// File: rtl/md_fix.sv
// Final sign correction, applied in the completion cycle.
module md_fix #(
  parameter int W = 32
) (
  input  logic [2*W-1:0] raw,
  input  logic           is_div,
  input  logic           neg_prod,
  input  logic           neg_quo,
  input  logic           neg_rem,
  output logic [W-1:0]   res_hi,
  output logic [W-1:0]   res_lo
);
  function automatic logic [2*W-1:0] neg_wide(input logic [2*W-1:0] x, input logic en);
    return en ? (~x + 1'b1) : x;
  endfunction

  function automatic logic [W-1:0] neg_half(input logic [W-1:0] x, input logic en);
    return en ? (~x + 1'b1) : x;
  endfunction

  logic [2*W-1:0] prod;

  always_comb begin
    prod = neg_wide(raw, neg_prod);
    if (is_div) begin
      res_hi = neg_half(raw[2*W-1:W], neg_rem);
      res_lo = neg_half(raw[W-1:0], neg_quo);
    end else begin
      res_hi = prod[2*W-1:W];
      res_lo = prod[W-1:0];
    end
  end

endmodule

// File: rtl/md_hilo.sv
// HI/LO result pair: completion has priority, moves only when allowed.
module md_hilo #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load_res,
  input  logic [W-1:0] res_hi,
  input  logic [W-1:0] res_lo,
  input  logic         mv_hi,
  input  logic         mv_lo,
  input  logic [W-1:0] mv_data,
  output logic [W-1:0] hi_q,
  output logic [W-1:0] lo_q
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hi_q <= '0;
      lo_q <= '0;
    end else if (load_res) begin
      hi_q <= res_hi;
      lo_q <= res_lo;
    end else begin
      if (mv_hi) hi_q <= mv_data;
      if (mv_lo) lo_q <= mv_data;
    end
  end
endmodule

// File: rtl/muldiv_unit.sv
module muldiv_unit #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic [1:0]   op,
  input  logic [W-1:0] src_a,
  input  logic [W-1:0] src_b,
  output logic         busy,
  input  logic         rd_req,
  input  logic         rd_sel,
  output logic [W-1:0] rd_data,
  output logic         rd_ready,
  input  logic         wr_hi,
  input  logic         wr_lo,
  input  logic [W-1:0] wr_data
);
  logic           accept_w;
  logic           done_w;
  logic           mv_hi_w, mv_lo_w;
  logic [2*W-1:0] init_work, raw_w;
  logic [W-1:0]   init_mcand;
  logic           p_div, p_nprod, p_nquo, p_nrem;
  logic           c_div, c_nprod, c_nquo, c_nrem;
  logic [W-1:0]   res_hi, res_lo;
  logic [W-1:0]   hi_q, lo_q;

  assign accept_w = start && !busy;
  assign mv_hi_w  = wr_hi && !busy;
  assign mv_lo_w  = wr_lo && !busy;

  md_prep #(.W(W)) u_prep (
    .op(op), .a(src_a), .b(src_b),
    .work_init(init_work), .mcand_init(init_mcand),
    .is_div(p_div), .neg_prod(p_nprod), .neg_quo(p_nquo), .neg_rem(p_nrem)
  );

  md_core #(.W(W)) u_core (
    .clk(clk), .rst_n(rst_n), .load(accept_w),
    .work_init(init_work), .mcand_init(init_mcand),
    .is_div_in(p_div), .neg_prod_in(p_nprod), .neg_quo_in(p_nquo), .neg_rem_in(p_nrem),
    .busy(busy), .done(done_w), .raw(raw_w),
    .is_div(c_div), .neg_prod(c_nprod), .neg_quo(c_nquo), .neg_rem(c_nrem)
  );

  md_fix #(.W(W)) u_fix (
    .raw(raw_w), .is_div(c_div), .neg_prod(c_nprod), .neg_quo(c_nquo), .neg_rem(c_nrem),
    .res_hi(res_hi), .res_lo(res_lo)
  );

  md_hilo #(.W(W)) u_hilo (
    .clk(clk), .rst_n(rst_n), .load_res(done_w),
    .res_hi(res_hi), .res_lo(res_lo),
    .mv_hi(mv_hi_w), .mv_lo(mv_lo_w), .mv_data(wr_data),
    .hi_q(hi_q), .lo_q(lo_q)
  );

  assign rd_ready = !busy;
  assign rd_data  = rd_req ? (rd_sel ? hi_q : lo_q) : '0;

endmodule

// File: rtl/muldiv_checker.sv
module muldiv_checker #(
  parameter int W = 32
) (
  input logic         clk,
  input logic         rst_n,
  input logic         start,
  input logic [1:0]   op,
  input logic [W-1:0] src_a,
  input logic [W-1:0] src_b,
  input logic         busy,
  input logic         done,
  input logic         wr_hi,
  input logic         wr_lo,
  input logic [W-1:0] wr_data,
  input logic [W-1:0] hi_q,
  input logic [W-1:0] lo_q
);
  import muldiv_pkg::*;

  logic [7:0]   run_len;
  logic [1:0]   l_op;
  logic [W-1:0] l_a, l_b;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run_len <= '0;
      l_op    <= '0;
      l_a     <= '0;
      l_b     <= '0;
    end else if (start && !busy) begin
      run_len <= '0;
      l_op    <= op;
      l_a     <= src_a;
      l_b     <= src_b;
    end else if (busy) begin
      run_len <= run_len + 1'b1;
    end
  end

  assert_launch_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(start));

  assert_length_R2: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (run_len == 8'(W - 1)));

  assert_idle_after_R12: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !busy);

  assert_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !done) |=> ($stable(hi_q) && $stable(lo_q)));

  assert_move_hi_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && wr_hi) |=> (hi_q == $past(wr_data)));

  assert_move_lo_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && wr_lo) |=> (lo_q == $past(wr_data)));

  assert_umul_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (done && l_op == OP_MUL_U) |=> ({hi_q, lo_q} == ({{W{1'b0}}, l_a} * {{W{1'b0}}, l_b})));

  assert_udiv_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (done && l_op == OP_DIV_U && l_b != '0) |=> (lo_q == l_a / l_b && hi_q == l_a % l_b));

endmodule

bind muldiv_unit muldiv_checker #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .op(op), .src_a(src_a), .src_b(src_b),
  .busy(busy), .done(done_w), .wr_hi(wr_hi), .wr_lo(wr_lo), .wr_data(wr_data),
  .hi_q(hi_q), .lo_q(lo_q)
);

// File: tb/tb_muldiv_unit.sv
`timescale 1ns/1ps
module tb_muldiv_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [1:0]  op = 2'b00;
  logic [31:0] src_a = '0, src_b = '0;
  logic        busy;
  logic        rd_req = 1'b0, rd_sel = 1'b0;
  logic [31:0] rd_data;
  logic        rd_ready;
  logic        wr_hi = 1'b0, wr_lo = 1'b0;
  logic [31:0] wr_data = '0;

  always #2 clk = ~clk;

  muldiv_unit dut (
    .clk(clk), .rst_n(rst_n), .start(start), .op(op), .src_a(src_a), .src_b(src_b),
    .busy(busy), .rd_req(rd_req), .rd_sel(rd_sel), .rd_data(rd_data), .rd_ready(rd_ready),
    .wr_hi(wr_hi), .wr_lo(wr_lo), .wr_data(wr_data)
  );

  // Behavioural reference
  logic [31:0] m_hi = '0, m_lo = '0, p_hi = '0, p_lo = '0;
  bit          m_busy = 1'b0;
  int          m_cnt = 0;
  int          n_cmp = 0, n_bad = 0, wd = 0;
  bit          checking = 1'b0;
  string       cur_req = "R1";

  task automatic ref_calc(input logic [1:0] c, input logic [31:0] a, input logic [31:0] b,
                          output logic [31:0] h, output logic [31:0] l);
    logic [63:0] up;
    longint      sp, sa, sb, q, r;
    sa = longint'($signed(a));
    sb = longint'($signed(b));
    case (c)
      2'b01: begin up = {32'b0, a} * {32'b0, b}; h = up[63:32]; l = up[31:0]; end
      2'b00: begin sp = sa * sb; h = sp[63:32]; l = sp[31:0]; end
      2'b11: begin
        if (b == 0) begin h = a; l = 32'hFFFF_FFFF; end
        else begin h = a % b; l = a / b; end
      end
      default: begin
        if (b == 0) begin h = a; l = (sa < 0) ? 32'd1 : 32'hFFFF_FFFF; end
        else begin q = sa / sb; r = sa % sb; h = r[31:0]; l = q[31:0]; end
      end
    endcase
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      m_hi = '0; m_lo = '0; m_busy = 1'b0; m_cnt = 0;
    end else if (m_busy) begin
      m_cnt++;
      if (m_cnt == 32) begin m_hi = p_hi; m_lo = p_lo; m_busy = 1'b0; end
    end else begin
      if (wr_hi) m_hi = wr_data;
      if (wr_lo) m_lo = wr_data;
      if (start) begin
        ref_calc(op, src_a, src_b, p_hi, p_lo);
        m_busy = 1'b1;
        m_cnt = 0;
      end
    end
  end

  task automatic check(input string what, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", cur_req, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (checking) begin
      check("busy", {31'b0, busy}, {31'b0, m_busy});
      check("rd_ready", {31'b0, rd_ready}, {31'b0, !m_busy});
      check("rd_data", rd_data, rd_req ? (rd_sel ? m_hi : m_lo) : 32'h0);
    end
  end

  always @(posedge clk) begin
    wd++;
    if (wd > 100000) begin
      n_bad++;
      $display("FAIL %s watchdog: actual %0d cycles expected below 100000", cur_req, wd);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic issue(input logic [1:0] c, input logic [31:0] a, input logic [31:0] b);
    start = 1'b1; op = c; src_a = a; src_b = b;
    step();
    start = 1'b0;
  endtask

  task automatic drain();
    rd_req = 1'b1;
    for (int i = 0; i < 40 && m_busy; i++) begin
      rd_sel = ~rd_sel;
      step();
    end
    rd_sel = 1'b1; step();
    rd_sel = 1'b0; step();
  endtask

  task automatic run_op(input string tag, input logic [1:0] c, input logic [31:0] a, input logic [31:0] b);
    cur_req = tag;
    issue(c, a, b);
    drain();
  endtask

  initial begin
    step();
    checking = 1'b1;
    step(); step();
    rst_n = 1'b1;
    // R1: reset contents read back through the port
    rd_req = 1'b1; rd_sel = 1'b1; step();
    rd_sel = 1'b0; step();
    // R8: no request drives zero
    cur_req = "R8";
    rd_req = 1'b0; step();
    // R10: moves while idle, single and together
    cur_req = "R10";
    wr_hi = 1'b1; wr_data = 32'hDEAD_0001; step();
    wr_hi = 1'b0; wr_lo = 1'b1; wr_data = 32'h0BAD_0002; step();
    wr_lo = 1'b0; rd_req = 1'b1; rd_sel = 1'b1; step();
    rd_sel = 1'b0; step();
    wr_hi = 1'b1; wr_lo = 1'b1; wr_data = 32'h5A5A_A5A5; step();
    wr_hi = 1'b0; wr_lo = 1'b0; rd_sel = 1'b1; step();
    rd_sel = 1'b0; step();
    // R3: unsigned products
    run_op("R3", 2'b01, 32'hFFFF_FFFF, 32'hFFFF_FFFF);
    run_op("R3", 2'b01, 32'h1234_5678, 32'h9ABC_DEF0);
    run_op("R3", 2'b01, 32'h0000_0000, 32'h7777_7777);
    // R4: signed products
    run_op("R4", 2'b00, 32'hFFFF_FFFF, 32'hFFFF_FFFF);
    run_op("R4", 2'b00, 32'h8000_0000, 32'h8000_0000);
    run_op("R4", 2'b00, 32'hFFFF_FFFD, 32'h0000_0007);
    run_op("R4", 2'b00, 32'h7FFF_FFFF, 32'h8000_0000);
    // R5: unsigned quotients
    run_op("R5", 2'b11, 32'd100, 32'd7);
    run_op("R5", 2'b11, 32'hFFFF_FFFF, 32'd3);
    run_op("R5", 2'b11, 32'd5, 32'd9);
    // R6: signed quotients and the overflow corner
    run_op("R6", 2'b10, 32'hFFFF_FFF9, 32'd2);
    run_op("R6", 2'b10, 32'd7, 32'hFFFF_FFFE);
    run_op("R6", 2'b10, 32'hFFFF_FFF9, 32'hFFFF_FFFE);
    run_op("R6", 2'b10, 32'h8000_0000, 32'hFFFF_FFFF);
    run_op("R6", 2'b10, 32'h8000_0000, 32'd1);
    // R7: divide by zero
    run_op("R7", 2'b11, 32'h0000_1234, 32'd0);
    run_op("R7", 2'b10, 32'hFFFF_FFFB, 32'd0);
    run_op("R7", 2'b10, 32'd5, 32'd0);
    // R9 and R2: ready and busy timing over a full run
    run_op("R9", 2'b01, 32'd3, 32'd5);
    run_op("R2", 2'b10, 32'd1000, 32'd10);
    // R11: moves held through the busy window, completion cycle included
    cur_req = "R11";
    issue(2'b01, 32'd6, 32'd7);
    wr_hi = 1'b1; wr_lo = 1'b1; wr_data = 32'hCAFE_F00D;
    for (int i = 0; i < 40 && m_busy; i++) step();
    wr_hi = 1'b0; wr_lo = 1'b0;
    drain();
    // R12: second launch while busy is dropped
    cur_req = "R12";
    issue(2'b11, 32'd77, 32'd4);
    step(); step(); step();
    issue(2'b01, 32'h0001_0000, 32'h0001_0000);
    drain();
    // R13: read together with a launch sees the old value
    cur_req = "R13";
    rd_req = 1'b1; rd_sel = 1'b1;
    issue(2'b00, 32'hFFFF_FFF0, 32'd16);
    rd_sel = 1'b0;
    drain();
    checking = 1'b0;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule